// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds the wall-clock time and date as eight fields: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. Each pulse on the update strobe adds one second. Any carry passes through every field up to the century within that same update. Leap years follow the Gregorian rule, using the full four-digit year built from the century and year fields.

Two mode bits set how the fields appear on the output bytes and how load data is read. The data-mode bit selects packed BCD or plain binary. The hour-format bit selects 24-hour or 12-hour form. In 12-hour form the hour reads 1 to 12 and bit 7 is set for PM. A host freezes counting with the freeze input and then writes single fields through a field-select code. The write data is read in the encoding that the mode bits currently select.

Control is a two-state machine. ST_COUNT is the reset state: update strobes advance the time and load requests are ignored. ST_FROZEN ignores update strobes and accepts loads. The transition ST_COUNT to ST_FROZEN is taken on a clock edge where freeze is 1. The transition ST_FROZEN to ST_COUNT is taken on an edge where freeze is 0. Because the state is registered, a strobe or a load is judged by the state held before that edge.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the block is in ST_COUNT and holds 2000-01-01, day of week 7, 00:00:00. With BCD and 24-hour mode the outputs read sec 0x00, min 0x00, hour 0x00, wday 0x07, mday 0x01, mon 0x01, year 0x00, cent 0x20.
- R2: In ST_COUNT each clock edge with tick high adds one second. An edge with tick low leaves every field unchanged.
- R3: With bin_mode 0 every output byte is packed BCD, tens in bits 7:4 and units in bits 3:0. With bin_mode 1 it is the plain binary value. Changing the mode re-encodes the same time without altering it.
- R4: With h24_mode 1 the hours run 0 to 23. A tick at 23:59:59 gives 00:00:00 and advances the date.
- R5: With h24_mode 0 the hour byte carries 12 for hour 0 and for hour 12, and the hour minus 12 for hours 13 to 23. Bit 7 is 1 for hours 12 to 23. BCD noon reads 0x92 and BCD midnight reads 0x12.
- R6: Day of month wraps to 1 after 30 for months 4, 6, 9 and 11, and after 31 for the other months. February wraps after 29 in a leap year and after 28 otherwise. A leap year is divisible by 4 and either not divisible by 100 or divisible by 400.
- R7: Month wraps from 12 to 1 and advances the year. Year wraps from 99 to 0 and advances the century. Century wraps from 99 to 0. The century changes only on a tick that wraps the year.
- R8: Day of week runs 1 to 7 and steps at every midnight, wrapping from 7 to 1.
- R9: In ST_FROZEN ticks are ignored, and ld_en writes ld_data to the field picked by ld_sel. The codes are 0 sec, 1 min, 2 hour, 3 wday, 4 mday, 5 mon, 6 year, 7 cent. In 12-hour mode bit 7 of a loaded hour marks PM.
- R10: In ST_COUNT ld_en has no effect.
- R11: A single tick at 2099-12-31 23:59:59 gives 2100-01-01 00:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second update strobe |
| freeze | input | 1 | Requests ST_FROZEN (counting stopped, loads open) |
| bin_mode | input | 1 | 1 = binary fields, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM flag |
| ld_en | input | 1 | Field load request |
| ld_sel | input | 3 | Field code for the load |
| ld_data | input | 8 | Load value in the current encoding |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| wday_o | output | 8 | Day-of-week byte |
| mday_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year-in-century byte |
| cent_o | output | 8 | Century byte |

## Verification
The month-end, leap-year and century cases only occur about once in millions of ticks when counting from reset, so they cannot be reached by counting alone. The stimulus freezes the counter and loads a date one second before each boundary: Feb 28 in 2023, 2024, 2100 and 2000, the end of a 30-day month, Dec 31 2099, and Dec 31 9999. It then releases the freeze and ticks across the boundary. The loads alternate between BCD and binary, and between 12-hour and 24-hour modes, so the load decode path is exercised as well as the count path.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int unsigned VAL_W  = 7;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NUM_FIELDS = 8;
    localparam int unsigned SEL_W  = $clog2(NUM_FIELDS);

    localparam logic [SEL_W-1:0] FLD_SEC  = 3'd0;
    localparam logic [SEL_W-1:0] FLD_MIN  = 3'd1;
    localparam logic [SEL_W-1:0] FLD_HOUR = 3'd2;
    localparam logic [SEL_W-1:0] FLD_WDAY = 3'd3;
    localparam logic [SEL_W-1:0] FLD_MDAY = 3'd4;
    localparam logic [SEL_W-1:0] FLD_MON  = 3'd5;
    localparam logic [SEL_W-1:0] FLD_YEAR = 3'd6;
    localparam logic [SEL_W-1:0] FLD_CENT = 3'd7;

    typedef struct packed {
        logic [VAL_W-1:0] sec;
        logic [VAL_W-1:0] min;
        logic [VAL_W-1:0] hour;
        logic [VAL_W-1:0] wday;
        logic [VAL_W-1:0] mday;
        logic [VAL_W-1:0] mon;
        logic [VAL_W-1:0] year;
        logic [VAL_W-1:0] cent;
    } cal_t;

    typedef enum logic {ST_COUNT, ST_FROZEN} cal_state_e;

    function automatic logic [BYTE_W-1:0] bin2bcd(input logic [VAL_W-1:0] v);
        logic [BYTE_W-1:0] r;
        r = {1'b0, v};
        return ((r / 8'd10) << 4) | (r % 8'd10);
    endfunction

    function automatic logic [VAL_W-1:0] bcd2bin(input logic [BYTE_W-1:0] b);
        return 7'({4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]});
    endfunction

    function automatic logic leap_year(input logic [VAL_W-1:0] yr,
                                       input logic [VAL_W-1:0] ce);
        return (yr[1:0] == 2'd0) && ((yr != '0) || (ce[1:0] == 2'd0));
    endfunction

    function automatic logic [VAL_W-1:0] month_len(input logic [VAL_W-1:0] mo,
                                                   input logic leap);
        case (mo)
            7'd2:                    return leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
            default:                 return 7'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic sec_w, min_w, hr_w, mday_w, mon_w, year_w;
    logic [VAL_W-1:0] last_day;

    always_comb begin
        last_day = month_len(cur.mon, leap_year(cur.year, cur.cent));
        sec_w  = cur.sec  >= 7'd59;
        min_w  = cur.min  >= 7'd59;
        hr_w   = cur.hour >= 7'd23;
        mday_w = cur.mday >= last_day;
        mon_w  = cur.mon  >= 7'd12;
        year_w = cur.year >= 7'd99;

        nxt = cur;
        nxt.sec = sec_w ? '0 : cur.sec + 7'd1;
        if (sec_w) begin
            nxt.min = min_w ? '0 : cur.min + 7'd1;
            if (min_w) begin
                nxt.hour = hr_w ? '0 : cur.hour + 7'd1;
                if (hr_w) begin
                    nxt.wday = (cur.wday >= 7'd7) ? 7'd1 : cur.wday + 7'd1;
                    nxt.mday = mday_w ? 7'd1 : cur.mday + 7'd1;
                    if (mday_w) begin
                        nxt.mon = mon_w ? 7'd1 : cur.mon + 7'd1;
                        if (mon_w) begin
                            nxt.year = year_w ? '0 : cur.year + 7'd1;
                            if (year_w)
                                nxt.cent = (cur.cent >= 7'd99) ? '0 : cur.cent + 7'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_cal_load.sv
module rtc_cal_load
    import rtc_cal_pkg::*;
(
    input  cal_t              cur,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] data,
    input  logic              bin_mode,
    input  logic              h24_mode,
    output cal_t              loaded
);
    logic [VAL_W-1:0]  plain_v, hour_raw, hour_v;
    logic [BYTE_W-1:0] hour_src;

    always_comb begin
        plain_v  = bin_mode ? data[6:0] : bcd2bin(data);
        hour_src = h24_mode ? data : {1'b0, data[6:0]};
        hour_raw = bin_mode ? hour_src[6:0] : bcd2bin(hour_src);
        if (h24_mode)
            hour_v = hour_raw;
        else
            hour_v = ((hour_raw == 7'd12) ? 7'd0 : hour_raw) + (data[7] ? 7'd12 : 7'd0);

        loaded = cur;
        unique case (sel)
            FLD_SEC:  loaded.sec  = plain_v;
            FLD_MIN:  loaded.min  = plain_v;
            FLD_HOUR: loaded.hour = hour_v;
            FLD_WDAY: loaded.wday = plain_v;
            FLD_MDAY: loaded.mday = plain_v;
            FLD_MON:  loaded.mon  = plain_v;
            FLD_YEAR: loaded.year = plain_v;
            FLD_CENT: loaded.cent = plain_v;
        endcase
    end
endmodule

// File: rtl/rtc_field_enc.sv
module rtc_field_enc
    import rtc_cal_pkg::*;
#(
    parameter bit HOUR_FIELD = 1'b0
) (
    input  logic [VAL_W-1:0]  val,
    input  logic              bin_mode,
    input  logic              h24_mode,
    output logic [BYTE_W-1:0] byte_o
);
    logic [VAL_W-1:0]  h12;
    logic              pm;
    logic [BYTE_W-1:0] plain_b, h12_b;

    always_comb begin
        pm      = val >= 7'd12;
        h12     = (val == 7'd0) ? 7'd12 : (pm && val != 7'd12) ? val - 7'd12 : val;
        plain_b = bin_mode ? {1'b0, val} : bin2bcd(val);
        h12_b   = (bin_mode ? {1'b0, h12} : bin2bcd(h12)) | {pm, 7'd0};
        byte_o  = (HOUR_FIELD && !h24_mode) ? h12_b : plain_b;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int unsigned RST_CENT = 20,
    parameter int unsigned RST_YEAR = 0,
    parameter int unsigned RST_MON  = 1,
    parameter int unsigned RST_MDAY = 1,
    parameter int unsigned RST_WDAY = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       freeze,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       ld_en,
    input  logic [2:0] ld_sel,
    input  logic [7:0] ld_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o
);
    localparam cal_t RST_CAL = '{sec: '0, min: '0, hour: '0,
                                 wday: 7'(RST_WDAY), mday: 7'(RST_MDAY),
                                 mon: 7'(RST_MON), year: 7'(RST_YEAR),
                                 cent: 7'(RST_CENT)};

    cal_state_e state, state_nxt;
    cal_t cal, cal_adv, cal_ld;

    rtc_cal_advance u_adv (.cur(cal), .nxt(cal_adv));

    rtc_cal_load u_ld (
        .cur(cal), .sel(ld_sel), .data(ld_data),
        .bin_mode(bin_mode), .h24_mode(h24_mode), .loaded(cal_ld)
    );

    always_comb begin
        unique case (state)
            ST_COUNT:  state_nxt = freeze ? ST_FROZEN : ST_COUNT;
            ST_FROZEN: state_nxt = freeze ? ST_FROZEN : ST_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COUNT;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal <= RST_CAL;
        end else begin
            unique case (state)
                ST_COUNT:  if (tick)  cal <= cal_adv;
                ST_FROZEN: if (ld_en) cal <= cal_ld;
            endcase
        end
    end

    logic [VAL_W-1:0]  fval  [NUM_FIELDS];
    logic [BYTE_W-1:0] fbyte [NUM_FIELDS];

    always_comb begin
        fval[0] = cal.sec;  fval[1] = cal.min;  fval[2] = cal.hour; fval[3] = cal.wday;
        fval[4] = cal.mday; fval[5] = cal.mon;  fval[6] = cal.year; fval[7] = cal.cent;
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_enc
        rtc_field_enc #(.HOUR_FIELD(g == 2)) u_enc (
            .val(fval[g]), .bin_mode(bin_mode), .h24_mode(h24_mode), .byte_o(fbyte[g])
        );
    end

    always_comb begin
        sec_o  = fbyte[0]; min_o  = fbyte[1]; hour_o = fbyte[2]; wday_o = fbyte[3];
        mday_o = fbyte[4]; mon_o  = fbyte[5]; year_o = fbyte[6]; cent_o = fbyte[7];
    end

    assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && !ld_en) |=> $stable(cal));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !tick) |=> $stable(cal));

    assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && tick && cal.sec < 7'd59)
        |=> (cal.sec == $past(cal.sec) + 7'd1) && $stable(cal.min));

    assert_cent_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && tick && cal.year != 7'd99) |=> $stable(cal.cent));
endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    logic clk = 0, rst_n = 0, tick = 0, freeze = 0, bin_mode = 0, h24_mode = 1, ld_en = 0;
    logic [2:0] ld_sel = 0;
    logic [7:0] ld_data = 0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o;

    int checks = 0, fails = 0;
    bit done = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    rtc_calendar_core dut (.*);

    // behavioural reference
    int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year, m_cent;
    bit m_frz;

    function automatic int mdays(int mo, int y, int c);
        int full = c * 100 + y;
        bit lp = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int enc(int v);
        return bin_mode ? v : ((v / 10) * 16 + v % 10);
    endfunction

    function automatic int dec(int d);
        return bin_mode ? (d & 127) : ((((d >> 4) * 10) + (d & 15)) & 127);
    endfunction

    function automatic int henc(int h);
        if (h24_mode) return enc(h);
        return enc((h % 12 == 0) ? 12 : h % 12) | ((h >= 12) ? 128 : 0);
    endfunction

    task automatic m_advance();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hour++;
        if (m_hour < 24) return;
        m_hour = 0;
        m_wday = (m_wday == 7) ? 1 : m_wday + 1;
        m_mday++;
        if (m_mday <= mdays(m_mon, m_year, m_cent)) return;
        m_mday = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1; m_year++;
        if (m_year < 100) return;
        m_year = 0; m_cent = (m_cent + 1) % 100;
    endtask

    task automatic m_load();
        int v;
        if (ld_sel == 2) begin
            if (h24_mode) v = dec(ld_data);
            else v = (dec(ld_data & 127) % 12) + (ld_data[7] ? 12 : 0);
        end else v = dec(ld_data);
        case (ld_sel)
            0: m_sec = v;  1: m_min = v;  2: m_hour = v; 3: m_wday = v;
            4: m_mday = v; 5: m_mon = v;  6: m_year = v; default: m_cent = v;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_wday = 7; m_mday = 1;
            m_mon = 1; m_year = 0; m_cent = 20; m_frz = 0;
        end else begin
            if (!m_frz) begin
                if (tick) m_advance();
            end else if (ld_en) m_load();
            m_frz = freeze;
        end
    end

    task automatic compare();
        logic [63:0] got, exp;
        got = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o};
        exp = {8'(enc(m_sec)), 8'(enc(m_min)), 8'(henc(m_hour)), 8'(enc(m_wday)),
               8'(enc(m_mday)), 8'(enc(m_mon)), 8'(enc(m_year)), 8'(enc(m_cent))};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: outputs %h expected %h", tag, got, exp);
        end
    endtask

    task automatic lit(string t, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, got, exp);
        end
    endtask

    task automatic cyc(bit tk, bit ld = 0, int sel = 0, int data = 0);
        tick = tk; ld_en = ld; ld_sel = 3'(sel); ld_data = 8'(data);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic set_time(int c, int y, int mo, int d, int w, int h, int mi, int s);
        freeze = 1; cyc(0);
        cyc(0, 1, 0, enc(s));  cyc(0, 1, 1, enc(mi)); cyc(0, 1, 2, henc(h));
        cyc(0, 1, 3, enc(w));  cyc(0, 1, 4, enc(d));  cyc(0, 1, 5, enc(mo));
        cyc(0, 1, 6, enc(y));  cyc(0, 1, 7, enc(c));
        freeze = 0; cyc(0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1; checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        compare();                                       // R1
        lit("R1 sec", sec_o, 8'h00);  lit("R1 hour", hour_o, 8'h00);
        lit("R1 wday", wday_o, 8'h07); lit("R1 mday", mday_o, 8'h01);
        lit("R1 mon", mon_o, 8'h01);  lit("R1 cent", cent_o, 8'h20);

        tag = "R2";
        for (int i = 0; i < 12; i++) cyc(i % 3 != 1);

        tag = "R3";
        set_time(20, 24, 7, 15, 2, 12, 34, 56);
        for (int i = 0; i < 8; i++) begin bin_mode = i[1]; cyc(i[0]); end
        bin_mode = 0;

        tag = "R4";
        set_time(20, 23, 6, 15, 4, 23, 59, 58);
        for (int i = 0; i < 3; i++) cyc(1);

        tag = "R5";
        h24_mode = 0;
        set_time(20, 23, 6, 15, 4, 11, 59, 59);
        cyc(1);
        lit("R5 noon", hour_o, 8'h92);
        set_time(20, 23, 6, 15, 4, 23, 59, 59);
        cyc(1);
        lit("R5 midnight", hour_o, 8'h12);
        bin_mode = 1;
        set_time(20, 23, 6, 15, 4, 21, 59, 59);
        cyc(1); cyc(1);
        bin_mode = 0;
        freeze = 1; cyc(0);
        cyc(0, 1, 2, 8'h91);                             // 11 PM loaded in BCD
        freeze = 0; cyc(0);
        h24_mode = 1; cyc(0);
        lit("R5 load pm", hour_o, 8'h23);

        tag = "R6";
        set_time(20, 23, 2, 28, 3, 23, 59, 59); cyc(1); cyc(1);
        set_time(20, 24, 2, 28, 3, 23, 59, 59); cyc(1);
        lit("R6 leap 29", mday_o, 8'h29);
        set_time(20, 24, 2, 29, 3, 23, 59, 59); cyc(1);
        set_time(21, 0, 2, 28, 3, 23, 59, 59); cyc(1);
        lit("R6 2100 mar", mon_o, 8'h03);
        bin_mode = 1;
        set_time(20, 0, 2, 28, 3, 23, 59, 59); cyc(1);
        set_time(20, 23, 4, 30, 3, 23, 59, 59); cyc(1);
        set_time(20, 23, 1, 31, 3, 23, 59, 59); cyc(1);
        set_time(20, 23, 11, 30, 3, 23, 59, 59); cyc(1);
        set_time(20, 23, 8, 30, 3, 23, 59, 59); cyc(1);
        bin_mode = 0;

        tag = "R11";
        set_time(20, 99, 12, 31, 5, 23, 59, 59); cyc(1);
        lit("R11 year", year_o, 8'h00); lit("R11 cent", cent_o, 8'h21);
        lit("R11 mon", mon_o, 8'h01);   lit("R11 mday", mday_o, 8'h01);

        tag = "R7";
        set_time(99, 99, 12, 31, 5, 23, 59, 59); cyc(1);
        lit("R7 cent wrap", cent_o, 8'h00);
        set_time(20, 45, 12, 31, 1, 23, 59, 59); cyc(1); cyc(1);

        tag = "R8";
        set_time(20, 23, 3, 10, 7, 23, 59, 59); cyc(1);
        lit("R8 wday wrap", wday_o, 8'h01);

        tag = "R9";
        freeze = 1;
        cyc(1);                                          // still counts: state was ST_COUNT
        for (int i = 0; i < 6; i++) cyc(1);
        cyc(1, 1, 0, 8'h42);
        cyc(1, 1, 4, 8'h17);
        freeze = 0; cyc(1, 1, 1, 8'h05);                 // load accepted while still frozen
        cyc(1);

        tag = "R10";
        for (int i = 0; i < 6; i++) cyc(i % 2 == 0, 1, i, 8'h11);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule